// File: doc/BRIEF.md
# Password Verifier with Retry Lockout

This block decides whether a serial memory's protocol engine may open a protected transaction. The engine shifts a 64-bit candidate password into the block one byte at a time. It then pulses a check strobe and selects whether the access is a write or a read. The block compares the candidate with the matching stored password and raises a grant if they agree.

Every check, passed or failed, starts a forced busy period. This stands in for the nonvolatile update that makes guessing slow. A poll answer is high only when the grant is held and the busy period is over. Wrong attempts of either kind feed one shared counter. A wrong attempt made once that counter has reached its limit starts a wipe. The wipe zeroes both passwords at once and then clears the data array one byte per clock.

A holder of the write grant can load a new read or write password from the candidate register. A holder of the read grant sees the array through a read port. The stored passwords and the data array are ordinary registers here.

Top module: `pw_guard`

## Requirements
- R1: After reset both passwords are zero, the retry count is 0, and grant, grant_is_write, poll_ack and busy are all low.
- R2: Each pw_byte_valid cycle shifts pw_byte into the candidate, and the first byte sent becomes the most significant byte. A check with check_is_write=1 compares against the write password; with check_is_write=0 it compares against the read password.
- R3: A matching check sets grant, sets grant_is_write to check_is_write, and returns the retry count to 0.
- R4: A mismatching check clears grant. If the retry count is below RETRY_LIMIT it goes up by one, and read and write failures add to the same count.
- R5: Each accepted check or password change holds busy high for exactly BUSY_CYCLES clock cycles. While busy is high, candidate bytes, checks and password changes are ignored.
- R6: poll_ack is high only while grant is held and busy is low. After a wrong password it stays low even once busy ends.
- R7: A mismatching check made while the retry count equals RETRY_LIMIT starts a wipe. Both passwords become zero, every array byte becomes zero, busy stays high for ARR_BYTES cycles, and the retry count is then 0.
- R8: session_end clears grant on the next clock.
- R9: While the write grant is held, chg_valid copies the candidate into the write password (chg_is_write=1) or into the read password (chg_is_write=0).
- R10: Array writes take effect only while the write grant is held and busy is low. arr_rd_data shows the addressed byte only while the read grant is held and busy is low, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pw_byte_valid | input | 1 | Shift pw_byte into the candidate |
| pw_byte | input | 8 | Candidate password byte |
| check_strobe | input | 1 | Compare the candidate now |
| check_is_write | input | 1 | 1 selects the write password, 0 the read password |
| chg_valid | input | 1 | Store the candidate as a new password |
| chg_is_write | input | 1 | 1 targets the write password, 0 the read password |
| session_end | input | 1 | Transaction over; drop the grant |
| arr_wr_en | input | 1 | Array byte write request |
| arr_wr_addr | input | AW | Array write address |
| arr_wr_data | input | 8 | Array write data |
| arr_rd_addr | input | AW | Array read address |
| arr_rd_data | output | 8 | Array read data, gated by the read grant |
| grant | output | 1 | Access granted |
| grant_is_write | output | 1 | Grant type: 1 write, 0 read |
| poll_ack | output | 1 | Answer to a password poll |
| busy | output | 1 | Nonvolatile update or wipe in progress |
| retry_cnt | output | RW | Failed-attempt count |

## Verification
Four properties are checked on every cycle:
- Any accepted check raises busy on the next clock.
- A grant rises only after an accepted check.
- session_end removes the grant.
- The retry count never passes its limit, and both passwords stay zero throughout a wipe.

Other properties need multi-step scenarios in the bench:
- The exact busy and wipe lengths.
- The byte order of the candidate.
- That read and write failures share one count.
- That the ninth failure really clears stored data.
- That stimulus applied during busy leaves no trace.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_NVWAIT = 2'd1,
        ST_WIPE   = 2'd2
    } pwg_state_e;
endpackage

// File: rtl/pwg_timer.sv
module pwg_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R5
    timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/pwg_store.sv
module pwg_store #(
    parameter int DEPTH = 112,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_addr,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    function automatic logic in_range(input logic [AW-1:0] a);
        return {1'b0, a} < (AW+1)'(DEPTH);
    endfunction

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (clr_en && in_range(clr_addr))
            mem_d[clr_addr] = 8'h00;
        else if (wr_en && in_range(wr_addr))
            mem_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = in_range(rd_addr) ? mem_q[rd_addr] : 8'h00;

    // R7
    wipe_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && in_range(clr_addr)) |=> (mem_q[$past(clr_addr)] == 8'h00));
endmodule

// File: rtl/pw_guard.sv
module pw_guard #(
    parameter  int PW_BYTES    = 8,
    parameter  int ARR_BYTES   = 112,
    parameter  int RETRY_LIMIT = 8,
    parameter  int BUSY_CYCLES = 16,
    localparam int AW          = $clog2(ARR_BYTES),
    localparam int RW          = $clog2(RETRY_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pw_byte_valid,
    input  logic [7:0]    pw_byte,
    input  logic          check_strobe,
    input  logic          check_is_write,
    input  logic          chg_valid,
    input  logic          chg_is_write,
    input  logic          session_end,
    input  logic          arr_wr_en,
    input  logic [AW-1:0] arr_wr_addr,
    input  logic [7:0]    arr_wr_data,
    input  logic [AW-1:0] arr_rd_addr,
    output logic [7:0]    arr_rd_data,
    output logic          grant,
    output logic          grant_is_write,
    output logic          poll_ack,
    output logic          busy,
    output logic [RW-1:0] retry_cnt
);
    import pwg_pkg::*;

    localparam int PW_W = 8 * PW_BYTES;
    localparam int TW   = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        pwg_state_e      st;
        logic [PW_W-1:0] cand;
        logic [PW_W-1:0] rpw;
        logic [PW_W-1:0] wpw;
        logic            grant;
        logic            gwr;
        logic [RW-1:0]   retry;
        logic [AW-1:0]   waddr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic t_load, t_zero, clr_en, match, st_wr_en;
    logic [7:0] st_rd_data;

    always_comb begin
        ctl_d  = ctl_q;
        t_load = 1'b0;
        clr_en = 1'b0;
        match  = ctl_q.cand == (check_is_write ? ctl_q.wpw : ctl_q.rpw);
        if (session_end) ctl_d.grant = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (pw_byte_valid)
                    ctl_d.cand = {ctl_q.cand[PW_W-9:0], pw_byte};
                if (check_strobe) begin
                    if (match) begin
                        ctl_d.grant = 1'b1;
                        ctl_d.gwr   = check_is_write;
                        ctl_d.retry = '0;
                        ctl_d.st    = ST_NVWAIT;
                        t_load      = 1'b1;
                    end else if (ctl_q.retry == RW'(RETRY_LIMIT)) begin
                        ctl_d.grant = 1'b0;
                        ctl_d.rpw   = '0;
                        ctl_d.wpw   = '0;
                        ctl_d.waddr = '0;
                        ctl_d.st    = ST_WIPE;
                    end else begin
                        ctl_d.grant = 1'b0;
                        ctl_d.retry = ctl_q.retry + 1'b1;
                        ctl_d.st    = ST_NVWAIT;
                        t_load      = 1'b1;
                    end
                end else if (chg_valid && ctl_q.grant && ctl_q.gwr) begin
                    if (chg_is_write) ctl_d.wpw = ctl_q.cand;
                    else              ctl_d.rpw = ctl_q.cand;
                    ctl_d.st = ST_NVWAIT;
                    t_load   = 1'b1;
                end
            end
            ST_NVWAIT: begin
                if (t_zero) ctl_d.st = ST_IDLE;
            end
            ST_WIPE: begin
                clr_en = 1'b1;
                if (ctl_q.waddr == AW'(ARR_BYTES - 1)) begin
                    ctl_d.st    = ST_IDLE;
                    ctl_d.retry = '0;
                end else begin
                    ctl_d.waddr = ctl_q.waddr + 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pwg_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (TW'(BUSY_CYCLES - 1)),
        .zero     (t_zero)
    );

    assign st_wr_en = arr_wr_en && ctl_q.grant && ctl_q.gwr && (ctl_q.st == ST_IDLE);

    pwg_store #(.DEPTH(ARR_BYTES), .AW(AW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (st_wr_en),
        .wr_addr  (arr_wr_addr),
        .wr_data  (arr_wr_data),
        .clr_en   (clr_en),
        .clr_addr (ctl_q.waddr),
        .rd_addr  (arr_rd_addr),
        .rd_data  (st_rd_data)
    );

    assign busy           = (ctl_q.st != ST_IDLE);
    assign grant          = ctl_q.grant;
    assign grant_is_write = ctl_q.gwr;
    assign poll_ack       = ctl_q.grant && !busy;
    assign retry_cnt      = ctl_q.retry;
    assign arr_rd_data    = (ctl_q.grant && !ctl_q.gwr && !busy) ? st_rd_data : 8'h00;

    // R5
    busy_after_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (check_strobe && !busy) |=> busy);
    // R3
    grant_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> $past(check_strobe && !busy));
    // R8
    session_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (session_end && !(check_strobe && !busy)) |=> !grant);
    // R4
    retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_cnt <= RW'(RETRY_LIMIT));
    // R7
    wipe_pw_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WIPE) |-> (ctl_q.rpw == '0 && ctl_q.wpw == '0));
endmodule

// File: tb/pw_guard_test.sv
module pw_guard_test;
    localparam int ARR  = 112;
    localparam int BUSY = 16;
    localparam int LIM  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pw_byte_valid = 0, check_strobe = 0, check_is_write = 0;
    logic chg_valid = 0, chg_is_write = 0, session_end = 0, arr_wr_en = 0;
    logic [7:0] pw_byte = 0, arr_wr_data = 0, arr_rd_data;
    logic [6:0] arr_wr_addr = 0, arr_rd_addr = 0;
    logic grant, grant_is_write, poll_ack, busy;
    logic [3:0] retry_cnt;
    int vectors = 0, fails = 0;

    localparam logic [63:0] WPW = 64'h1122_3344_5566_7788;
    localparam logic [63:0] RPW = 64'hA1B2_C3D4_E5F6_0718;
    localparam logic [63:0] BAD = 64'hDEAD_BEEF_0BAD_F00D;

    always #10 clk = ~clk;

    pw_guard uut (
        .clk(clk), .rst_n(rst_n), .pw_byte_valid(pw_byte_valid), .pw_byte(pw_byte),
        .check_strobe(check_strobe), .check_is_write(check_is_write),
        .chg_valid(chg_valid), .chg_is_write(chg_is_write), .session_end(session_end),
        .arr_wr_en(arr_wr_en), .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data),
        .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data), .grant(grant),
        .grant_is_write(grant_is_write), .poll_ack(poll_ack), .busy(busy),
        .retry_cnt(retry_cnt)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_pw(input logic [63:0] p);
        for (int i = 0; i < 8; i++) begin
            pw_byte_valid = 1'b1;
            pw_byte = p[63 - 8*i -: 8];
            tick();
        end
        pw_byte_valid = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            tick();
        end
    endtask

    task automatic do_check(input logic w, output int n);
        check_strobe = 1'b1;
        check_is_write = w;
        tick();
        check_strobe = 1'b0;
        count_busy(n);
    endtask

    task automatic do_chg(input logic w, output int n);
        chg_valid = 1'b1;
        chg_is_write = w;
        tick();
        chg_valid = 1'b0;
        count_busy(n);
    endtask

    task automatic end_session();
        session_end = 1'b1;
        tick();
        session_end = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 grant", grant, 0);
        chk("R1 busy", busy, 0);
        chk("R1 poll_ack", poll_ack, 0);
        chk("R1 retry", retry_cnt, 0);
        chk("R1 grant_is_write", grant_is_write, 0);
    endtask

    task automatic t_default_pw();
        int n;
        send_pw(64'h0);
        do_check(1'b0, n);
        chk("R5 busy length read check", n, BUSY);
        chk("R3 grant on zero read pw", grant, 1);
        chk("R3 grant type read", grant_is_write, 0);
        chk("R6 poll_ack after busy", poll_ack, 1);
        end_session();
        chk("R8 grant dropped", grant, 0);
        chk("R6 poll_ack dropped", poll_ack, 0);
    endtask

    task automatic t_change_pw();
        int n;
        send_pw(64'h0);
        do_check(1'b1, n);
        chk("R3 write grant", grant_is_write, 1);
        send_pw(WPW);
        do_chg(1'b1, n);
        chk("R9 busy length change", n, BUSY);
        send_pw(RPW);
        do_chg(1'b0, n);
        end_session();
        send_pw(RPW);
        do_check(1'b0, n);
        chk("R9 new read pw accepted", grant, 1);
        end_session();
        send_pw(WPW);
        do_check(1'b1, n);
        chk("R9 new write pw accepted", grant, 1);
        chk("R2 write check uses write pw", grant_is_write, 1);
        end_session();
        send_pw(RPW);
        do_check(1'b1, n);
        chk("R2 read pw rejected for write", grant, 0);
        chk("R4 retry after one wrong", retry_cnt, 1);
        send_pw(WPW);
        do_check(1'b1, n);
        chk("R3 retry cleared on match", retry_cnt, 0);
        end_session();
    endtask

    task automatic t_byte_order();
        int n;
        send_pw({WPW[7:0], WPW[15:8], WPW[23:16], WPW[31:24],
                 WPW[39:32], WPW[47:40], WPW[55:48], WPW[63:56]});
        do_check(1'b1, n);
        chk("R2 reversed byte order rejected", grant, 0);
        send_pw(WPW);
        do_check(1'b1, n);
        chk("R2 msb-first accepted", grant, 1);
        end_session();
    endtask

    task automatic t_shared_retry();
        int n;
        send_pw(BAD);
        do_check(1'b1, n);
        chk("R4 wrong write retry", retry_cnt, 1);
        chk("R6 poll_ack low after wrong", poll_ack, 0);
        send_pw(BAD);
        do_check(1'b0, n);
        chk("R4 wrong read shares count", retry_cnt, 2);
        send_pw(RPW);
        do_check(1'b0, n);
        chk("R3 retry reset", retry_cnt, 0);
        end_session();
    endtask

    task automatic t_array();
        int n;
        send_pw(WPW);
        do_check(1'b1, n);
        arr_wr_en = 1; arr_wr_addr = 7'd5; arr_wr_data = 8'hA5; tick();
        arr_wr_addr = 7'd111; arr_wr_data = 8'h3C; tick();
        arr_wr_en = 0;
        end_session();
        arr_wr_en = 1; arr_wr_addr = 7'd5; arr_wr_data = 8'hFF; tick();
        arr_wr_en = 0;
        arr_rd_addr = 7'd5; tick();
        chk("R10 read hidden without grant", arr_rd_data, 8'h00);
        send_pw(RPW);
        do_check(1'b0, n);
        tick();
        chk("R10 read byte 5", arr_rd_data, 8'hA5);
        arr_rd_addr = 7'd111; tick();
        chk("R10 read byte 111", arr_rd_data, 8'h3C);
        end_session();
    endtask

    task automatic t_busy_ignore();
        int n;
        send_pw(RPW);
        check_strobe = 1'b1; check_is_write = 1'b0; tick();
        check_strobe = 1'b0;
        send_pw(BAD);
        check_strobe = 1'b1; check_is_write = 1'b1; tick();
        check_strobe = 1'b0;
        chg_valid = 1'b1; tick(); chg_valid = 1'b0;
        n = 10;
        while (busy && n < 1000) begin n++; tick(); end
        chk("R5 busy not extended", n, BUSY);
        chk("R5 stray check ignored retry", retry_cnt, 0);
        do_check(1'b0, n);
        chk("R5 candidate untouched while busy", grant, 1);
        end_session();
    endtask

    task automatic t_lockout();
        int n;
        for (int k = 1; k <= LIM; k++) begin
            send_pw(BAD);
            do_check(k[0], n);
        end
        chk("R4 retry at limit", retry_cnt, LIM);
        chk("R5 no wipe at limit", n, BUSY);
        send_pw(BAD);
        do_check(1'b0, n);
        chk("R7 wipe busy length", n, ARR);
        chk("R7 retry cleared after wipe", retry_cnt, 0);
        send_pw(64'h0);
        do_check(1'b0, n);
        chk("R7 read pw zeroed", grant, 1);
        arr_rd_addr = 7'd5; tick();
        chk("R7 byte 5 wiped", arr_rd_data, 8'h00);
        arr_rd_addr = 7'd111; tick();
        chk("R7 byte 111 wiped", arr_rd_data, 8'h00);
        end_session();
        send_pw(64'h0);
        do_check(1'b1, n);
        chk("R7 write pw zeroed", grant, 1);
        end_session();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_default_pw();
        t_change_pw();
        t_byte_order();
        t_shared_retry();
        t_array();
        t_busy_ignore();
        t_lockout();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule